// File: doc/BRIEF.md
# Bidirectional FIFO Register Port

This block gives a local processor one 32-bit register window that leads to two independent queues. A local read of the window takes the oldest word from the inbound queue, which the host side fills. A local write to the window adds a word to the outbound queue, which the host side drains. Because reads and writes reach different storage, a word written through the window never comes back through it.

Two flag outputs let local transfer logic pace itself. One reports that there is nothing to read, and the other reports that there is no room to write. A second register window reports each queue's occupancy state and two sticky overflow bits. A mode input turns on 64-bit endian conversion. In that mode, words move in pairs, each pair is byte-reversed across its full 64 bits, and both flags count whole pairs. The mode is meant to change only while both queues are idle.

Top module: `dual_fifo_port`

## Requirements
- R1: With `mode64` low, a local read with `locAddr` = PORT_OFS (default 0x20) places the oldest inbound word on `locRdData` at the clock edge that samples the read, and words leave in host push order.
- R2: A local write with `locAddr` = PORT_OFS enters the outbound queue. The host sees those words on `hostPopData` in write order, and none of them ever appears on `locRdData` through a port read.
- R3: With `mode64` low, `rdEmpty` is high exactly when the inbound queue holds no word, and `wrFull` is high exactly when the outbound queue holds DEPTH words.
- R4: A port read while `rdEmpty` is high leaves `locRdData` at its previous value and removes nothing from the inbound queue.
- R5: A port write while `wrFull` is high is dropped and sets status bit 9. A host push while `hostInFull` is high is dropped and sets status bit 8. Both bits stay set until reset.
- R6: A local read with `locAddr` = STAT_OFS (default 0x24) returns the status word. Bit 0 is inbound empty, bit 1 is inbound at least half full, and bit 2 is inbound full. Bits 4, 5 and 6 give the same three flags for the outbound queue. Bits 8 and 9 are the overflow bits from R5. Every other bit reads 0.
- R7: With `mode64` high, the host pushes e0 then e1. The first port read returns byteSwap(e1) and the second returns byteSwap(e0). byteSwap reverses the four bytes of a word.
- R8: With `mode64` high, the local side writes d0 then d1. Nothing is visible to the host after d0. After d1, the host pops byteSwap(d1) and then byteSwap(d0).
- R9: With `mode64` high, at the start of a pair `rdEmpty` stays high while fewer than two inbound words are present. Once the first read of a pair has taken place, `rdEmpty` is low until the second read. At the start of a pair, `wrFull` is high while fewer than two outbound slots are free.
- R10: A synchronous reset empties both queues, clears both overflow bits and sets `locRdData` to 0. After reset the status word reads 0x11.
- R11: A local read at any other address returns 0, and a local write at any other address changes neither queue.
- R12: `hostInFull` is high when the inbound queue holds DEPTH words, `hostOutEmpty` is high when the outbound queue is empty, and `hostPopData` always shows the oldest outbound word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode64 | input | 1 | Enables paired 64-bit endian conversion |
| locAddr | input | ADDR_W | Local register address |
| locRd | input | 1 | Local read strobe |
| locWr | input | 1 | Local write strobe |
| locWrData | input | 32 | Local write data |
| locRdData | output | 32 | Local read data, registered |
| rdEmpty | output | 1 | No data can be read at the port |
| wrFull | output | 1 | No space for a port write |
| hostPush | input | 1 | Host push into the inbound queue |
| hostPushData | input | 32 | Host push data |
| hostInFull | output | 1 | Inbound queue full |
| hostPop | input | 1 | Host pop from the outbound queue |
| hostPopData | output | 32 | Oldest outbound word |
| hostOutEmpty | output | 1 | Outbound queue empty |

## Verification
The bench builds the block with its defaults: DEPTH 8, ADDR_W 8, the port at 0x20 and the status at 0x24. With a depth of 8, the half-full threshold is reached after four words and both full conditions after eight, so every overflow path is reached within a few dozen cycles. With seven outbound words, one slot remains free. That case separates the single-word full rule from the pair rule when `mode64` is switched on.

// File: rtl/dual_fifo_port_pkg.sv
package dual_fifo_port_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_N = WORD_W / 8;

  // status word bit positions
  localparam int ST_IN_EMPTY  = 0;
  localparam int ST_IN_HALF   = 1;
  localparam int ST_IN_FULL   = 2;
  localparam int ST_OUT_EMPTY = 4;
  localparam int ST_OUT_HALF  = 5;
  localparam int ST_OUT_FULL  = 6;
  localparam int ST_IN_OVF    = 8;
  localparam int ST_OUT_OVF   = 9;

  typedef enum logic [2:0] {
    RD_KEEP, RD_HEAD, RD_PAIR, RD_HOLD, RD_STATUS, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   inPush;
    logic   inPop;
    logic   inPopPair;
    logic   outPushOne;
    logic   outPushPair;
    logic   outPop;
    logic   wrLatch;
    rdSel_e rdSel;
  } strobe_t;

  function automatic logic [WORD_W-1:0] byteSwap(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < BYTE_N; b++) begin
      r[8*b +: 8] = w[WORD_W-8-8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/dual_fifo_port_ctrl.sv
module dual_fifo_port_ctrl
  import dual_fifo_port_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 8,
  parameter int PORT_OFS = 'h20,
  parameter int STAT_OFS = 'h24,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              locRd,
  input  logic              locWr,
  input  logic              hostPush,
  input  logic              hostPop,
  output strobe_t           strb,
  output logic [PTR_W-1:0]  inWrPtr,
  output logic [PTR_W-1:0]  inRdPtr,
  output logic [PTR_W-1:0]  outWrPtr,
  output logic [PTR_W-1:0]  outRdPtr,
  output logic [WORD_W-1:0] statusWord,
  output logic              rdEmpty,
  output logic              wrFull,
  output logic              hostInFull,
  output logic              hostOutEmpty
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);

  logic [CNT_W-1:0] inCount, outCount, outFree;
  logic             rdPhase, wrPhase, inOvf, outOvf;
  logic             portSel, statSel;
  logic [1:0]       inDec, outInc;

  always_comb begin
    portSel      = (locAddr == ADDR_W'(PORT_OFS));
    statSel      = (locAddr == ADDR_W'(STAT_OFS));
    outFree      = FULL_CNT - outCount;
    hostInFull   = (inCount == FULL_CNT);
    hostOutEmpty = (outCount == '0);
    rdEmpty      = mode64 ? (!rdPhase && (inCount < TWO)) : (inCount == '0);
    wrFull       = mode64 ? (!wrPhase && (outFree < TWO)) : (outFree == '0);
  end

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_KEEP;
    if (locRd) begin
      if (portSel) begin
        if (!rdEmpty) begin
          if (!mode64) begin
            strb.inPop = 1'b1;
            strb.rdSel = RD_HEAD;
          end else if (!rdPhase) begin
            strb.inPopPair = 1'b1;
            strb.rdSel     = RD_PAIR;
          end else begin
            strb.rdSel = RD_HOLD;
          end
        end
      end else if (statSel) begin
        strb.rdSel = RD_STATUS;
      end else begin
        strb.rdSel = RD_ZERO;
      end
    end
    if (locWr && portSel && !wrFull) begin
      if (!mode64)       strb.outPushOne  = 1'b1;
      else if (!wrPhase) strb.wrLatch     = 1'b1;
      else               strb.outPushPair = 1'b1;
    end
    strb.inPush = hostPush && !hostInFull;
    strb.outPop = hostPop && !hostOutEmpty;
  end

  always_comb begin
    inDec  = strb.inPopPair ? 2'd2 : (strb.inPop ? 2'd1 : 2'd0);
    outInc = strb.outPushPair ? 2'd2 : (strb.outPushOne ? 2'd1 : 2'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inCount  <= '0;
      outCount <= '0;
      inWrPtr  <= '0;
      inRdPtr  <= '0;
      outWrPtr <= '0;
      outRdPtr <= '0;
      rdPhase  <= 1'b0;
      wrPhase  <= 1'b0;
      inOvf    <= 1'b0;
      outOvf   <= 1'b0;
    end else begin
      inCount  <= inCount + CNT_W'(strb.inPush) - CNT_W'(inDec);
      outCount <= outCount + CNT_W'(outInc) - CNT_W'(strb.outPop);
      inWrPtr  <= inWrPtr + PTR_W'(strb.inPush);
      inRdPtr  <= inRdPtr + PTR_W'(inDec);
      outWrPtr <= outWrPtr + PTR_W'(outInc);
      outRdPtr <= outRdPtr + PTR_W'(strb.outPop);
      if (!mode64)                    rdPhase <= 1'b0;
      else if (strb.inPopPair)        rdPhase <= 1'b1;
      else if (strb.rdSel == RD_HOLD) rdPhase <= 1'b0;
      if (!mode64)               wrPhase <= 1'b0;
      else if (strb.wrLatch)     wrPhase <= 1'b1;
      else if (strb.outPushPair) wrPhase <= 1'b0;
      if (hostPush && hostInFull)       inOvf  <= 1'b1;
      if (locWr && portSel && wrFull)   outOvf <= 1'b1;
    end
  end

  always_comb begin
    statusWord               = '0;
    statusWord[ST_IN_EMPTY]  = (inCount == '0);
    statusWord[ST_IN_HALF]   = (inCount >= HALF_CNT);
    statusWord[ST_IN_FULL]   = hostInFull;
    statusWord[ST_OUT_EMPTY] = hostOutEmpty;
    statusWord[ST_OUT_HALF]  = (outCount >= HALF_CNT);
    statusWord[ST_OUT_FULL]  = (outCount == FULL_CNT);
    statusWord[ST_IN_OVF]    = inOvf;
    statusWord[ST_OUT_OVF]   = outOvf;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (inCount <= FULL_CNT) && (outCount <= FULL_CNT)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (inOvf || outOvf) |=> ($past(inOvf) -> inOvf) && ($past(outOvf) -> outOvf)); // R5
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (locWr && portSel && wrFull && !hostPop) |=> (outCount == $past(outCount))); // R5
  AST_EMPTY_NOPOP: assert property (@(posedge clk) disable iff (rst)
    (locRd && portSel && rdEmpty && !hostPush) |=> (inCount == $past(inCount))); // R4
  AST_PAIR_POP: assert property (@(posedge clk) disable iff (rst)
    (strb.inPopPair && !hostPush) |=> (inCount == $past(inCount) - TWO)); // R7
endmodule

// File: rtl/dual_fifo_port_dp.sv
module dual_fifo_port_dp
  import dual_fifo_port_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [PTR_W-1:0]  inWrPtr,
  input  logic [PTR_W-1:0]  inRdPtr,
  input  logic [PTR_W-1:0]  outWrPtr,
  input  logic [PTR_W-1:0]  outRdPtr,
  input  logic [WORD_W-1:0] statusWord,
  input  logic [WORD_W-1:0] hostPushData,
  input  logic [WORD_W-1:0] locWrData,
  output logic [WORD_W-1:0] locRdData,
  output logic [WORD_W-1:0] hostPopData
);
  logic [WORD_W-1:0] inMem  [DEPTH];
  logic [WORD_W-1:0] outMem [DEPTH];
  logic [WORD_W-1:0] holdRd, holdWr;
  logic [PTR_W-1:0]  inRdNext, outWrNext;

  assign inRdNext    = inRdPtr + PTR_W'(1);
  assign outWrNext   = outWrPtr + PTR_W'(1);
  assign hostPopData = outMem[outRdPtr];

  always_ff @(posedge clk) begin
    if (strb.inPush)     inMem[inWrPtr] <= hostPushData;
    if (strb.outPushOne) outMem[outWrPtr] <= locWrData;
    if (strb.outPushPair) begin
      outMem[outWrPtr]  <= byteSwap(locWrData);
      outMem[outWrNext] <= byteSwap(holdWr);
    end
    if (strb.wrLatch)   holdWr <= locWrData;
    if (strb.inPopPair) holdRd <= byteSwap(inMem[inRdPtr]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locRdData <= '0;
    end else begin
      case (strb.rdSel)
        RD_HEAD:   locRdData <= inMem[inRdPtr];
        RD_PAIR:   locRdData <= byteSwap(inMem[inRdNext]);
        RD_HOLD:   locRdData <= holdRd;
        RD_STATUS: locRdData <= statusWord;
        RD_ZERO:   locRdData <= '0;
        default:   locRdData <= locRdData;
      endcase
    end
  end

  AST_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
    (strb.rdSel == RD_KEEP) |=> $stable(locRdData)); // R4
endmodule

// File: rtl/dual_fifo_port.sv
module dual_fifo_port
  import dual_fifo_port_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 8,
  parameter int PORT_OFS = 'h20,
  parameter int STAT_OFS = 'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              locRd,
  input  logic              locWr,
  input  logic [31:0]       locWrData,
  output logic [31:0]       locRdData,
  output logic              rdEmpty,
  output logic              wrFull,
  input  logic              hostPush,
  input  logic [31:0]       hostPushData,
  output logic              hostInFull,
  input  logic              hostPop,
  output logic [31:0]       hostPopData,
  output logic              hostOutEmpty
);
  localparam int PTR_W = $clog2(DEPTH);

  strobe_t           strb;
  logic [PTR_W-1:0]  inWrPtr, inRdPtr, outWrPtr, outRdPtr;
  logic [WORD_W-1:0] statusWord;

  dual_fifo_port_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PORT_OFS(PORT_OFS), .STAT_OFS(STAT_OFS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mode64(mode64), .locAddr(locAddr),
    .locRd(locRd), .locWr(locWr), .hostPush(hostPush), .hostPop(hostPop),
    .strb(strb), .inWrPtr(inWrPtr), .inRdPtr(inRdPtr),
    .outWrPtr(outWrPtr), .outRdPtr(outRdPtr), .statusWord(statusWord),
    .rdEmpty(rdEmpty), .wrFull(wrFull),
    .hostInFull(hostInFull), .hostOutEmpty(hostOutEmpty)
  );

  dual_fifo_port_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .inWrPtr(inWrPtr), .inRdPtr(inRdPtr),
    .outWrPtr(outWrPtr), .outRdPtr(outRdPtr),
    .statusWord(statusWord), .hostPushData(hostPushData),
    .locWrData(locWrData), .locRdData(locRdData), .hostPopData(hostPopData)
  );
endmodule

// File: tb/dual_fifo_port_bench.sv
module dual_fifo_port_bench;
  localparam logic [7:0] PORT = 8'h20;
  localparam logic [7:0] STAT = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode64 = 1'b0;
  logic [7:0]  locAddr = '0;
  logic        locRd = 1'b0, locWr = 1'b0;
  logic [31:0] locWrData = '0, locRdData;
  logic        rdEmpty, wrFull;
  logic        hostPush = 1'b0, hostPop = 1'b0;
  logic [31:0] hostPushData = '0, hostPopData;
  logic        hostInFull, hostOutEmpty;

  int  nChecks = 0, nFails = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  dual_fifo_port u_dual_fifo_port (
    .clk(clk), .rst(rst), .mode64(mode64), .locAddr(locAddr),
    .locRd(locRd), .locWr(locWr), .locWrData(locWrData), .locRdData(locRdData),
    .rdEmpty(rdEmpty), .wrFull(wrFull), .hostPush(hostPush),
    .hostPushData(hostPushData), .hostInFull(hostInFull), .hostPop(hostPop),
    .hostPopData(hostPopData), .hostOutEmpty(hostOutEmpty)
  );

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic locRead(input logic [7:0] a, output logic [31:0] d);
    locAddr = a; locRd = 1'b1;
    @(negedge clk);
    locRd = 1'b0;
    d = locRdData;
  endtask

  task automatic locWrite(input logic [7:0] a, input logic [31:0] d);
    locAddr = a; locWr = 1'b1; locWrData = d;
    @(negedge clk);
    locWr = 1'b0;
  endtask

  task automatic hPush(input logic [31:0] d);
    hostPush = 1'b1; hostPushData = d;
    @(negedge clk);
    hostPush = 1'b0;
  endtask

  task automatic hPop(output logic [31:0] d);
    d = hostPopData;
    hostPop = 1'b1;
    @(negedge clk);
    hostPop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 rdData", locRdData, 32'h0);
    chk("R10 rdEmpty", 32'(rdEmpty), 32'h1);
    chk("R10 wrFull", 32'(wrFull), 32'h0);
    chk("R12 outEmpty", 32'(hostOutEmpty), 32'h1);
    locRead(STAT, d);
    chk("R6 status after reset", d, 32'h11);
  endtask

  task automatic t_order();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) hPush(32'hA000_0000 + 32'(i));
    chk("R3 rdEmpty low", 32'(rdEmpty), 32'h0);
    for (int i = 0; i < 3; i++) begin
      locRead(PORT, d);
      chk("R1 order", d, 32'hA000_0000 + 32'(i));
    end
    chk("R3 rdEmpty high", 32'(rdEmpty), 32'h1);
  endtask

  task automatic t_isolation();
    logic [31:0] d;
    locWrite(PORT, 32'hCAFE_0001);
    locWrite(PORT, 32'hCAFE_0002);
    locRead(PORT, d);
    chk("R2 no readback", d, 32'hA000_0002);
    chk("R12 outEmpty low", 32'(hostOutEmpty), 32'h0);
    hPop(d);
    chk("R2 pop first", d, 32'hCAFE_0001);
    hPop(d);
    chk("R2 pop second", d, 32'hCAFE_0002);
    chk("R12 outEmpty high", 32'(hostOutEmpty), 32'h1);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    locRead(PORT, d);
    chk("R4 keep data", d, 32'hA000_0002);
    hPush(32'hBEEF_0001);
    locRead(PORT, d);
    chk("R4 nothing lost", d, 32'hBEEF_0001);
    chk("R4 empty again", 32'(rdEmpty), 32'h1);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) locWrite(PORT, 32'hD000_0000 + 32'(i));
    chk("R3 wrFull", 32'(wrFull), 32'h1);
    locRead(STAT, d);
    chk("R6 out full/half", d & 32'h70, 32'h60);
    locWrite(PORT, 32'hDEAD_DEAD);
    locRead(STAT, d);
    chk("R5 out overflow", d & 32'h300, 32'h200);
    for (int i = 0; i < 8; i++) begin
      hPop(d);
      chk("R5 dropped write absent", d, 32'hD000_0000 + 32'(i));
    end
    chk("R3 wrFull cleared", 32'(wrFull), 32'h0);
    for (int i = 0; i < 9; i++) hPush(32'hE000_0000 + 32'(i));
    chk("R12 hostInFull", 32'(hostInFull), 32'h1);
    locRead(STAT, d);
    chk("R5 sticky both", d & 32'h307, 32'h306);
    for (int i = 0; i < 8; i++) begin
      locRead(PORT, d);
      chk("R5 dropped push absent", d, 32'hE000_0000 + 32'(i));
    end
    chk("R5 nothing extra", 32'(rdEmpty), 32'h1);
  endtask

  task automatic t_half();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) hPush(32'(i));
    locRead(STAT, d);
    chk("R6 below half", 32'(d[1]), 32'h0);
    hPush(32'h3);
    locRead(STAT, d);
    chk("R6 half", 32'(d[1]), 32'h1);
    for (int i = 0; i < 4; i++) locRead(PORT, d);
    chk("R6 drained", d, 32'h3);
  endtask

  task automatic t_m64_in();
    logic [31:0] d;
    mode64 = 1'b1;
    hPush(32'h1122_3344);
    chk("R9 one word empty", 32'(rdEmpty), 32'h1);
    hPush(32'h5566_7788);
    chk("R9 pair ready", 32'(rdEmpty), 32'h0);
    locRead(PORT, d);
    chk("R7 first", d, swapBytes(32'h5566_7788));
    chk("R9 mid pair", 32'(rdEmpty), 32'h0);
    locRead(PORT, d);
    chk("R7 second", d, swapBytes(32'h1122_3344));
    chk("R9 after pair", 32'(rdEmpty), 32'h1);
    mode64 = 1'b0;
  endtask

  task automatic t_m64_out();
    logic [31:0] d;
    mode64 = 1'b1;
    locWrite(PORT, 32'h0102_0304);
    chk("R8 half pair hidden", 32'(hostOutEmpty), 32'h1);
    locWrite(PORT, 32'hA0B0_C0D0);
    hPop(d);
    chk("R8 first", d, 32'hD0C0_B0A0);
    hPop(d);
    chk("R8 second", d, 32'h0403_0201);
    mode64 = 1'b0;
  endtask

  task automatic t_m64_full();
    logic [31:0] d;
    for (int i = 0; i < 7; i++) locWrite(PORT, 32'(i));
    chk("R3 one slot left", 32'(wrFull), 32'h0);
    mode64 = 1'b1;
    @(negedge clk);
    chk("R9 pair full", 32'(wrFull), 32'h1);
    mode64 = 1'b0;
    for (int i = 0; i < 7; i++) hPop(d);
    chk("R9 drained", d, 32'h6);
  endtask

  task automatic t_other();
    logic [31:0] d;
    locWrite(8'h00, 32'h1234_5678);
    chk("R11 write ignored", 32'(hostOutEmpty), 32'h1);
    locRead(8'h28, d);
    chk("R11 read zero", d, 32'h0);
  endtask

  task automatic t_reset_clears();
    logic [31:0] d;
    hPush(32'h77);
    locWrite(PORT, 32'h88);
    doReset();
    chk("R10 inbound empty", 32'(rdEmpty), 32'h1);
    chk("R10 outbound empty", 32'(hostOutEmpty), 32'h1);
    chk("R10 rdData zero", locRdData, 32'h0);
    locRead(STAT, d);
    chk("R10 overflow cleared", d, 32'h11);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    t_reset();
    t_order();
    t_isolation();
    t_empty_read();
    t_full();
    t_half();
    t_m64_in();
    t_m64_out();
    t_m64_full();
    t_other();
    t_reset_clears();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule